// File: doc/BRIEF.md
# Field-Interleaving Frame Store Writer

This block sits in the memory clock domain. It drains tagged bytes from the read side of a first-word-fall-through FIFO and packs them in pairs into memory words. It then presents each word, with its address, to the host port of an SDRAM controller. The FIFO carries three kinds of entries: pixel bytes, line-start markers and field-start markers. The markers steer an internal column counter, a line-within-field counter and a latched field bit. Each word lands at `(2*line + field) * WORDS_PER_LINE + column`. The lines of the two fields therefore end up interleaved into one progressive frame, not stored one field after the other.

A four-state machine runs the block. IDLE waits while the FIFO is empty and moves to FETCH when it holds an entry. FETCH pops one entry per cycle while entries remain and returns to IDLE on an empty FIFO. It moves to WRITE_REQ when a popped byte completes a word. WRITE_REQ holds the request, address and data until the controller acknowledges, then moves to WAIT_DONE. WAIT_DONE steps the column, raises the frame-done pulse if the word just written closed the frame, and always returns to FETCH. No FIFO entry is consumed while a write is outstanding.

Top module: `fsw_frame_writer`

## Requirements
- R1: After reset, `fifo_rd`, `wr_req` and `frame_done` are all low, and `fifo_rd` is never high while `fifo_empty` is high.
- R2: The `fifo_tag` encoding is as follows. 2'b00 is a pixel byte in `fifo_byte`. 2'b01 is a line start. 2'b10 is a field start, with the field bit in `fifo_byte[0]`. 2'b11 is consumed with no effect on packing, position or writes.
- R3: Two accepted pixel bytes form one word. The earlier byte goes in `wr_data[BYTE_W-1:0]` and the later byte in the upper half.
- R4: Each write address equals `(2*line + field) * WORDS_PER_LINE + column`. Here `line` is the line count within the field and `column` is the word index within the line.
- R5: A line start zeroes the column and discards any unpaired byte. Every line start after the first one that follows a field start advances the line count by one.
- R6: A field start sets the line count to 0, latches the field bit and zeroes the column.
- R7: Pixel bytes are dropped without effect in three cases: before the first line start of a field, after `WORDS_PER_LINE` words of a line, and on lines at or beyond `LINES_PER_FIELD`.
- R8: `wr_req` stays high, with `wr_addr` and `wr_data` stable, until `wr_ack`. `fifo_rd` stays low while `wr_req` is high.
- R9: `frame_done` pulses for exactly one cycle, right after the acknowledge of the last word of the last line of field 1, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_empty | input | 1 | FIFO holds no entry |
| fifo_tag | input | 2 | Kind of the entry at the FIFO head |
| fifo_byte | input | BYTE_W | Payload of the entry at the FIFO head |
| fifo_rd | output | 1 | Pops the head entry at this clock edge |
| wr_req | output | 1 | Write request to the memory controller |
| wr_addr | output | ADDR_W | Word address of the write |
| wr_data | output | 2*BYTE_W | Packed word to write |
| wr_ack | input | 1 | Controller accepts the pending write |
| frame_done | output | 1 | One-cycle pulse when the frame is complete |

## Verification
A corrupted line count or field bit shows up on the very next write as an address off by a whole line or more. A slipped byte phase shows up in the same write as swapped or mixed halves in `wr_data`. A column counter that fails to clear appears as a word placed past the line end, or as a missing write on the next line. A stuck state shows at once as a pop during a pending request or a request that never drops. A wrong terminal-word test shows as a missing, repeated or early `frame_done` relative to the count of acknowledged writes.

// File: rtl/fsw_pkg.sv
package fsw_pkg;

    typedef enum logic [1:0] {
        TAG_DATA  = 2'b00,
        TAG_LINE  = 2'b01,
        TAG_FIELD = 2'b10,
        TAG_RSVD  = 2'b11
    } tag_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WRITE_REQ,
        ST_WAIT_DONE
    } state_e;

endpackage

// File: rtl/fsw_pos_tracker.sv
module fsw_pos_tracker #(
    parameter int WPL = 720,
    parameter int LPF = 240,
    localparam int CW = $clog2(WPL + 1),
    localparam int LW = $clog2(LPF + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          field_start,
    input  logic          line_start,
    input  logic          field_in,
    input  logic          col_step,
    output logic          field_q,
    output logic [LW-1:0] line_q,
    output logic [CW-1:0] col_q,
    output logic          in_window,
    output logic          last_word
);

    logic seen_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= 1'b0;
            line_q  <= '0;
            col_q   <= '0;
            seen_q  <= 1'b0;
        end else if (field_start) begin
            field_q <= field_in;
            line_q  <= '0;
            col_q   <= '0;
            seen_q  <= 1'b0;
        end else if (line_start) begin
            col_q  <= '0;
            seen_q <= 1'b1;
            if (seen_q && line_q != LW'(LPF))
                line_q <= line_q + LW'(1);
        end else if (col_step) begin
            col_q <= col_q + CW'(1);
        end
    end

    assign in_window = seen_q && (line_q < LW'(LPF)) && (col_q < CW'(WPL));
    assign last_word = field_q && (line_q == LW'(LPF - 1)) && (col_q == CW'(WPL - 1));

    // R7: the column never runs past the end of a line
    assert_col_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_q <= CW'(WPL));

    // R7: a column step only follows a word that was inside the window
    assert_step_in_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
        col_step |-> in_window);

endmodule

// File: rtl/fsw_byte_packer.sv
module fsw_byte_packer #(
    parameter int BYTE_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                byte_en,
    input  logic [BYTE_W-1:0]   byte_in,
    output logic                word_ready,
    output logic [2*BYTE_W-1:0] word_q
);

    logic              phase_q;
    logic [BYTE_W-1:0] low_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
            low_q   <= '0;
            word_q  <= '0;
        end else if (clear) begin
            phase_q <= 1'b0;
        end else if (byte_en) begin
            if (!phase_q) begin
                low_q   <= byte_in;
                phase_q <= 1'b1;
            end else begin
                word_q  <= {byte_in, low_q};
                phase_q <= 1'b0;
            end
        end
    end

    assign word_ready = byte_en && phase_q;

    // R5: a marker and a byte never arrive in the same pop
    assert_clear_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        clear |-> !byte_en);

endmodule

// File: rtl/fsw_addr_calc.sv
module fsw_addr_calc #(
    parameter int WPL = 720,
    parameter int LPF = 240,
    localparam int CW = $clog2(WPL + 1),
    localparam int LW = $clog2(LPF + 1),
    localparam int AW = $clog2(2 * LPF * WPL)
) (
    input  logic          field,
    input  logic [LW-1:0] line,
    input  logic [CW-1:0] col,
    output logic [AW-1:0] addr
);

    logic [AW-1:0] row;

    always_comb begin
        row  = (AW'(line) << 1) | AW'(field);
        addr = row * AW'(WPL) + AW'(col);
    end

endmodule

// File: rtl/fsw_frame_writer.sv
module fsw_frame_writer
    import fsw_pkg::*;
#(
    parameter int BYTE_W          = 8,
    parameter int WORDS_PER_LINE  = 720,
    parameter int LINES_PER_FIELD = 240,
    localparam int ADDR_W = $clog2(2 * LINES_PER_FIELD * WORDS_PER_LINE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fifo_empty,
    input  logic [1:0]          fifo_tag,
    input  logic [BYTE_W-1:0]   fifo_byte,
    output logic                fifo_rd,
    output logic                wr_req,
    output logic [ADDR_W-1:0]   wr_addr,
    output logic [2*BYTE_W-1:0] wr_data,
    input  logic                wr_ack,
    output logic                frame_done
);

    localparam int CW = $clog2(WORDS_PER_LINE + 1);
    localparam int LW = $clog2(LINES_PER_FIELD + 1);

    state_e state_q, state_d;
    tag_e   tag;

    logic          pop, field_start, line_start, byte_en, col_step;
    logic          field_q, in_window, last_word, word_ready;
    logic [LW-1:0] line_q;
    logic [CW-1:0] col_q;

    assign tag         = tag_e'(fifo_tag);
    assign pop         = (state_q == ST_FETCH) && !fifo_empty;
    assign field_start = pop && (tag == TAG_FIELD);
    assign line_start  = pop && (tag == TAG_LINE);
    assign byte_en     = pop && (tag == TAG_DATA) && in_window;

    fsw_pos_tracker #(.WPL(WORDS_PER_LINE), .LPF(LINES_PER_FIELD)) tracker_i (
        .clk(clk), .rst_n(rst_n),
        .field_start(field_start), .line_start(line_start),
        .field_in(fifo_byte[0]), .col_step(col_step),
        .field_q(field_q), .line_q(line_q), .col_q(col_q),
        .in_window(in_window), .last_word(last_word)
    );

    fsw_byte_packer #(.BYTE_W(BYTE_W)) packer_i (
        .clk(clk), .rst_n(rst_n),
        .clear(field_start || line_start), .byte_en(byte_en),
        .byte_in(fifo_byte), .word_ready(word_ready), .word_q(wr_data)
    );

    fsw_addr_calc #(.WPL(WORDS_PER_LINE), .LPF(LINES_PER_FIELD)) addr_i (
        .field(field_q), .line(line_q), .col(col_q), .addr(wr_addr)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (!fifo_empty) state_d = ST_FETCH;
            ST_FETCH:     if (word_ready) state_d = ST_WRITE_REQ;
                          else if (fifo_empty) state_d = ST_IDLE;
            ST_WRITE_REQ: if (wr_ack) state_d = ST_WAIT_DONE;
            ST_WAIT_DONE: state_d = ST_FETCH;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        fifo_rd    = pop;
        wr_req     = (state_q == ST_WRITE_REQ);
        col_step   = (state_q == ST_WAIT_DONE);
        frame_done = (state_q == ST_WAIT_DONE) && last_word;
    end

    assert_no_pop_empty_R1: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> !fifo_empty);

    assert_no_pop_pending_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> !fifo_rd);

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

    assert_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_addr < ADDR_W'(2 * LINES_PER_FIELD * WORDS_PER_LINE)));

    assert_done_after_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> $past(wr_req && wr_ack));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

endmodule

// File: tb/fsw_frame_writer_tb.sv
module fsw_frame_writer_tb_top;

    localparam int BW  = 8;
    localparam int WPL = 2;
    localparam int LPF = 3;
    localparam int AW  = $clog2(2 * LPF * WPL);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fifo_empty = 1'b1;
    logic [1:0]    fifo_tag = 2'b00;
    logic [BW-1:0] fifo_byte = '0;
    logic          fifo_rd, wr_req, frame_done;
    logic          wr_ack = 1'b0;
    logic [AW-1:0] wr_addr;
    logic [2*BW-1:0] wr_data;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    logic [9:0]      fq[$];
    logic [AW-1:0]   cap_a[$];
    logic [2*BW-1:0] cap_d[$];
    logic [AW-1:0]   exp_a[$];
    logic [2*BW-1:0] exp_d[$];

    bit pop_now = 0;
    int ack_delay = 0;
    int wcnt = 0;
    int rd_viol = 0, hold_viol = 0;
    int fd_cnt = 0, fd_idx = -1;
    logic [AW-1:0]   hold_a;
    logic [2*BW-1:0] hold_d;

    always #4 clk = ~clk;

    fsw_frame_writer #(.BYTE_W(BW), .WORDS_PER_LINE(WPL), .LINES_PER_FIELD(LPF)) dut_i (
        .clk(clk), .rst_n(rst_n), .fifo_empty(fifo_empty), .fifo_tag(fifo_tag),
        .fifo_byte(fifo_byte), .fifo_rd(fifo_rd), .wr_req(wr_req), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_ack(wr_ack), .frame_done(frame_done)
    );

    // FIFO model: pops just after the edge at which the design consumed the head
    always @(posedge clk) begin
        #1;
        if (pop_now && fq.size() > 0) void'(fq.pop_front());
        fifo_empty = (fq.size() == 0);
        if (fq.size() > 0) begin
            fifo_tag  = fq[0][9:8];
            fifo_byte = fq[0][7:0];
        end
    end

    // controller model and observation, away from the active edge
    always @(negedge clk) begin
        pop_now = fifo_rd;
        if (fifo_rd && wr_req) rd_viol++;
        if (frame_done) begin fd_cnt++; fd_idx = cap_a.size(); end
        if (!wr_req) begin
            wr_ack = 1'b0;
            wcnt = 0;
        end else begin
            if (wcnt == 0) begin hold_a = wr_addr; hold_d = wr_data; end
            else if (wr_addr != hold_a || wr_data != hold_d) hold_viol++;
            if (wcnt >= ack_delay) begin
                wr_ack = 1'b1;
                cap_a.push_back(wr_addr);
                cap_d.push_back(wr_data);
            end
            wcnt++;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [1:0] t, input logic [7:0] b);
        fq.push_back({t, b});
    endtask

    task automatic expect_w(input int line, input int f, input int col, input logic [7:0] b0,
                            input logic [7:0] b1);
        exp_a.push_back(AW'((2 * line + f) * WPL + col));
        exp_d.push_back({b1, b0});
    endtask

    task automatic clear_all();
        cap_a.delete(); cap_d.delete(); exp_a.delete(); exp_d.delete();
        fd_cnt = 0; fd_idx = -1; rd_viol = 0; hold_viol = 0;
    endtask

    task automatic drain();
        while (fq.size() > 0) @(negedge clk);
        repeat (30) @(negedge clk);
    endtask

    task automatic compare(input string req);
        check(cap_a.size() == exp_a.size(), {req, " write count"}, cap_a.size(), exp_a.size());
        for (int i = 0; i < exp_a.size() && i < cap_a.size(); i++) begin
            check(cap_a[i] == exp_a[i], {req, " address"}, cap_a[i], exp_a[i]);
            check(cap_d[i] == exp_d[i], {req, " data"}, cap_d[i], exp_d[i]);
        end
    endtask

    // R1: quiet outputs after reset with an empty FIFO
    task automatic t_reset();
        check(fifo_rd == 1'b0, "R1 fifo_rd", fifo_rd, 0);
        check(wr_req == 1'b0, "R1 wr_req", wr_req, 0);
        check(frame_done == 1'b0, "R1 frame_done", frame_done, 0);
    endtask

    // R3 R4 R6 R9: two full fields interleave into one frame
    task automatic t_full_frame();
        clear_all();
        ack_delay = 0;
        for (int f = 0; f < 2; f++) begin
            push(2'b10, 8'(f));
            for (int l = 0; l < LPF; l++) begin
                push(2'b01, 8'h00);
                for (int i = 0; i < 2 * WPL; i++) push(2'b00, 8'(f * 64 + l * 16 + i));
                for (int c = 0; c < WPL; c++)
                    expect_w(l, f, c, 8'(f * 64 + l * 16 + 2 * c), 8'(f * 64 + l * 16 + 2 * c + 1));
            end
        end
        drain();
        compare("R4 R3 full frame");
        check(fd_cnt == 1, "R9 frame_done count", fd_cnt, 1);
        check(fd_idx == 2 * LPF * WPL, "R9 frame_done position", fd_idx, 2 * LPF * WPL);
    endtask

    // R5: a line start discards a lone byte and moves to the next line
    task automatic t_line_restart();
        clear_all();
        ack_delay = 1;
        push(2'b10, 8'h00);
        push(2'b01, 8'h00);
        push(2'b00, 8'hA1); push(2'b00, 8'hA2); push(2'b00, 8'hA3);
        push(2'b01, 8'h00);
        push(2'b00, 8'hB1); push(2'b00, 8'hB2);
        expect_w(0, 0, 0, 8'hA1, 8'hA2);
        expect_w(1, 0, 0, 8'hB1, 8'hB2);
        drain();
        compare("R5 line restart");
        check(fd_cnt == 0, "R9 no frame_done", fd_cnt, 0);
    endtask

    // R2 R6 R7: ignored tag, early bytes, line overrun and surplus lines
    task automatic t_drops();
        clear_all();
        ack_delay = 2;
        push(2'b10, 8'h01);
        push(2'b00, 8'hEE);
        push(2'b01, 8'h00);
        push(2'b00, 8'hC0); push(2'b11, 8'h77); push(2'b00, 8'hC1);
        push(2'b00, 8'hC2); push(2'b00, 8'hC3);
        push(2'b00, 8'hC4); push(2'b00, 8'hC5);
        push(2'b01, 8'h00);
        push(2'b01, 8'h00);
        push(2'b00, 8'hD0); push(2'b00, 8'hD1);
        push(2'b01, 8'h00);
        push(2'b00, 8'hE0); push(2'b00, 8'hE1); push(2'b00, 8'hE2); push(2'b00, 8'hE3);
        expect_w(0, 1, 0, 8'hC0, 8'hC1);
        expect_w(0, 1, 1, 8'hC2, 8'hC3);
        expect_w(2, 1, 0, 8'hD0, 8'hD1);
        drain();
        compare("R7 R2 drops");
        check(fd_cnt == 0, "R9 no frame_done on partial field", fd_cnt, 0);
    endtask

    // R8: slow acknowledge holds the request and stops FIFO reads
    task automatic t_slow_ack();
        clear_all();
        ack_delay = 6;
        push(2'b10, 8'h00);
        push(2'b01, 8'h00);
        for (int i = 0; i < 2 * WPL; i++) push(2'b00, 8'(8'h50 + i));
        push(2'b01, 8'h00);
        push(2'b00, 8'h60); push(2'b00, 8'h61);
        expect_w(0, 0, 0, 8'h50, 8'h51);
        expect_w(0, 0, 1, 8'h52, 8'h53);
        expect_w(1, 0, 0, 8'h60, 8'h61);
        drain();
        compare("R8 slow ack");
        check(rd_viol == 0, "R8 pop while pending", rd_viol, 0);
        check(hold_viol == 0, "R8 request held stable", hold_viol, 0);
        check(fifo_rd == 1'b0 && wr_req == 1'b0, "R1 quiet when drained", {fifo_rd, wr_req}, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_full_frame();
        t_line_restart();
        t_drops();
        t_slow_ack();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule